// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a synchronous host read and write single 32-bit words in an external asynchronous static RAM of 256K words. The host raises a request with a write flag, an 18-bit word address, write data and a four-bit active-high byte mask. The controller accepts one request at a time and then runs the RAM's pins through a fixed sequence. The length of each phase is a number of system clock cycles, taken from a parameter.

On the RAM side the controller drives a low-true select, a high-true second select, low-true output and write enables, four low-true byte strobes and the address bus. The data bus is split into a driven word, a drive-enable and a returned word, so the tri-state buffer sits outside the block. Each write is opened with the chip selected and its drivers off. It is always closed by raising write enable while the chip is still selected. A read returns the whole word with a one-cycle valid pulse, and lanes the host did not ask for come back as zero.

Top module: `sram_byte_ctrl`

## Requirements
- R1: During and after reset, with no request, the pins are idle: `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, all `mem_bw_n` bits 1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is taken on a rising clock edge with `req_valid` and `req_ready` both high. `req_ready` then stays low for exactly RD_CYC cycles after a read and TURN_CYC+WE_CYC+HOLD_CYC cycles after a write. After each request the pins return to the idle state of R1 for at least one cycle.
- R3: For the whole of a read: `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1. `mem_addr` holds the request address. Strobe bit i equals the inverse of mask bit i, where lane i is data bits 8i+7 down to 8i.
- R4: A read ends with `rsp_valid` high for exactly one cycle, in the first cycle `req_ready` is high again. For each lane i, `rsp_rdata` carries the `mem_dq_in` lane sampled on the last edge of the read if mask bit i is 1, and zero if it is 0.
- R5: During a write `mem_oe_n` stays 1. The first TURN_CYC cycles have the chip selected with `mem_we_n`=1 and `mem_dq_oe`=0. After them `mem_we_n` is low for exactly WE_CYC consecutive cycles.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low. It is high during the write-enable pulse and the HOLD_CYC cycles after it, and while it is high `mem_dq_out` equals the request's write data.
- R7: A write is ended by write enable: `mem_we_n` rises while the chip is still selected, and the select is released only after HOLD_CYC cycles. `mem_addr` and `mem_bw_n` do not change while the chip is selected.
- R8: During a write, strobe bit i is the inverse of mask bit i, so only masked-in lanes of the RAM change. A write with mask 0 leaves every strobe high and the stored word unchanged.
- R9: While `req_ready` is low, `req_valid` and the request fields are ignored. A request presented during a cycle in progress does not alter it and is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Active-high byte lane enables |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM second select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_bw_n | output | 4 | RAM byte strobes, active low |
| mem_addr | output | 18 | RAM address |
| mem_dq_out | output | 32 | Data to drive onto the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_in | input | 32 | Data seen on the RAM bus |

## Verification
The assertions assume that the external buffer drives the bus only when `mem_dq_oe` is high. They also assume the parameters are at least one cycle each, so every phase of a cycle exists. The stimulus holds `req_valid` only on idle edges, except in deliberate cases that keep it high, with different fields, across a busy period to show they have no effect. The bench's RAM model drives a fixed filler pattern on lanes that are not enabled, so masking errors cannot hide behind zeros.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } sbc_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } sbc_pins_t;

  function automatic int unsigned sbc_max4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sbc_phase_timer.sv
module sbc_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_HOLDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/sbc_lanes.sv
module sbc_lanes #(
  parameter int unsigned LANES = 4
) (
  input  logic               strobe_on,
  input  logic [LANES-1:0]   strobe_mask,
  input  logic [LANES-1:0]   rd_mask,
  input  logic [8*LANES-1:0] dq_in,
  output logic [LANES-1:0]   bw_n,
  output logic [8*LANES-1:0] rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bw_n[g]             = ~(strobe_on & strobe_mask[g]);
    assign rd_word[8*g +: 8]   = rd_mask[g] ? dq_in[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned WE_CYC   = 2,
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_ce2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_bw_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned MAXC  = sbc_max4(RD_CYC, TURN_CYC, WE_CYC, HOLD_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WE   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);

  // ---------------- state and latched request ----------------
  sbc_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_q;
  logic                accept;
  logic                capture;
  logic                tmr_load;
  logic [CNT_W-1:0]    tmr_val;
  logic                tmr_done;

  // next-cycle request view, used to form registered pin values
  logic [ADDR_W-1:0]   addr_nx;
  logic [DATA_W-1:0]   wdata_nx;
  logic [LANES-1:0]    mask_nx;

  sbc_pins_t           pins_q, pins_d;
  logic [LANES-1:0]    bw_n_q, bw_n_d;
  logic [ADDR_W-1:0]   maddr_q;
  logic [DATA_W-1:0]   dq_out_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;
  logic [DATA_W-1:0]   rd_word;
  logic                strobe_on;

  assign accept = req_valid && (state_q == ST_IDLE);

  sbc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
            tmr_val = LD_TURN;
          end else begin
            state_d = ST_READ;
            tmr_val = LD_RD;
          end
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (tmr_done) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WE;
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end
      end
      ST_WHOLD: begin
        if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    addr_nx  = accept ? req_addr  : addr_q;
    wdata_nx = accept ? req_wdata : wdata_q;
    mask_nx  = accept ? req_mask  : mask_q;
  end

  // pin values for the next cycle, decoded from the next state
  always_comb begin
    pins_d.ce_n  = (state_d == ST_IDLE);
    pins_d.ce2   = (state_d != ST_IDLE);
    pins_d.oe_n  = (state_d != ST_READ);
    pins_d.we_n  = (state_d != ST_WPULSE);
    pins_d.dq_oe = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    strobe_on    = (state_d != ST_IDLE);
  end

  sbc_lanes #(.LANES(LANES)) u_lanes (
    .strobe_on   (strobe_on),
    .strobe_mask (mask_nx),
    .rd_mask     (mask_q),
    .dq_in       (mem_dq_in),
    .bw_n        (bw_n_d),
    .rd_word     (rd_word)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      bw_n_q   <= '1;
      maddr_q  <= '0;
      dq_out_q <= '0;
    end else begin
      pins_q   <= pins_d;
      bw_n_q   <= bw_n_d;
      maddr_q  <= addr_nx;
      dq_out_q <= wdata_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata_q <= '0;
    end else if (capture) begin
      rsp_rdata_q <= rd_word;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign mem_ce_n   = pins_q.ce_n;
  assign mem_ce2    = pins_q.ce2;
  assign mem_oe_n   = pins_q.oe_n;
  assign mem_we_n   = pins_q.we_n;
  assign mem_dq_oe  = pins_q.dq_oe;
  assign mem_bw_n   = bw_n_q;
  assign mem_addr   = maddr_q;
  assign mem_dq_out = dq_out_q;

  // ---------------- assertions ----------------
  logic [CNT_W:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (!mem_we_n) begin
      we_low_cnt <= we_low_cnt + 1'b1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  AST_IDLE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe)); // R1
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5
  AST_WE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce2)); // R7
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n)); // R7
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bw_n))); // R7
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == (CNT_W+1)'(WE_CYC))); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_ce_n) |=> $stable(mem_addr) || mem_ce_n); // R9

endmodule

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 32;
  localparam int NL = DW / 8;
  localparam int RD_C = 3;
  localparam int TURN_C = 1;
  localparam int WE_C = 2;
  localparam int HOLD_C = 1;
  localparam int WR_BUSY = TURN_C + WE_C + HOLD_C;
  localparam logic [7:0] FILL = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [NL-1:0] req_mask;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [NL-1:0] mem_bw_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_byte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD_C), .TURN_CYC(TURN_C),
                   .WE_CYC(WE_C), .HOLD_CYC(HOLD_C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bw_n(mem_bw_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- RAM model ----------------
  logic [DW-1:0] ram [int unsigned];
  logic [DW-1:0] ref_mem [int unsigned];
  int wr_tick = 0;

  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0 && mem_ce2 === 1'b1 && mem_dq_oe === 1'b1) begin
      logic [DW-1:0] w;
      w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : '0;
      for (int i = 0; i < NL; i++)
        if (!mem_bw_n[i]) w[8*i +: 8] = mem_dq_out[8*i +: 8];
      ram[int'(mem_addr)] = w;
      wr_tick++;
    end
  end

  always @(mem_addr, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_bw_n, wr_tick) begin
    logic [DW-1:0] r;
    logic [DW-1:0] v;
    v = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : '0;
    for (int i = 0; i < NL; i++) begin
      if (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n && !mem_bw_n[i])
        r[8*i +: 8] = v[8*i +: 8];
      else
        r[8*i +: 8] = FILL;
    end
    mem_dq_in = r;
  end

  // ---------------- helpers ----------------
  function automatic logic [DW-1:0] lane_bits(logic [NL-1:0] m);
    logic [DW-1:0] e;
    for (int i = 0; i < NL; i++) e[8*i +: 8] = {8{m[i]}};
    return e;
  endfunction

  function automatic logic [DW-1:0] ref_read(logic [AW-1:0] a, logic [NL-1:0] m);
    logic [DW-1:0] v;
    v = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    return v & lane_bits(m);
  endfunction

  function automatic logic [AW-1:0] pick_addr(logic [31:0] r);
    case (r[9:8])
      2'd0: return AW'(r[3:0]);
      2'd1: return 18'h3FFF0 | AW'(r[3:0]);
      2'd2: return {r[3:0], 14'h0};
      default: return 18'h15555 ^ AW'(r[3:0]);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NL-1:0] m, input bit intrude);
    int busy;
    int we_low;
    bit pins_ok;
    bit first_ok;
    bit last_ok;
    bit data_ok;
    bit rv_quiet;
    @(negedge clk);
    check(req_ready === 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    if (intrude) begin
      // R9: a different request held on the port while busy
      req_write = 1'b1; req_addr = a; req_wdata = ~d; req_mask = '1;
    end else begin
      req_valid = 1'b0;
    end
    busy = 0; we_low = 0; pins_ok = 1; first_ok = 1; last_ok = 1; data_ok = 1; rv_quiet = 1;
    while (req_ready !== 1'b1 && busy < 64) begin
      if (mem_ce_n !== 1'b0 || mem_ce2 !== 1'b1 || mem_addr !== a || mem_bw_n !== ~m)
        pins_ok = 0;
      if (rsp_valid !== 1'b0) rv_quiet = 0;
      if (mem_dq_oe === 1'b1 && mem_oe_n !== 1'b1) data_ok = 0;
      if (wr) begin
        if (mem_oe_n !== 1'b1) pins_ok = 0;
        if (mem_we_n === 1'b0) we_low++;
        if (busy < TURN_C && (mem_we_n !== 1'b1 || mem_dq_oe !== 1'b0)) first_ok = 0;
        if (busy >= TURN_C && busy < TURN_C + WE_C && mem_we_n !== 1'b0) first_ok = 0;
        if (mem_dq_oe === 1'b1 && mem_dq_out !== d) data_ok = 0;
        if (busy >= TURN_C && mem_dq_oe !== 1'b1) data_ok = 0;
        if (busy >= TURN_C + WE_C && mem_we_n !== 1'b1) last_ok = 0;
      end else begin
        if (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 || mem_dq_oe !== 1'b0) pins_ok = 0;
      end
      busy++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) begin
      check(busy == WR_BUSY, "R2 write busy length", 64'(busy), 64'(WR_BUSY));
      check(pins_ok, "R8 write select, address and strobes", 64'(mem_bw_n), 64'(~m));
      check(first_ok && we_low == WE_C, "R5 turnaround and write pulse", 64'(we_low), 64'(WE_C));
      check(data_ok, "R6 data drive window and value", 64'(mem_dq_out), 64'(d));
      check(last_ok, "R7 write closed by write enable", 64'(last_ok), 64'd1);
      check(rsp_valid === 1'b0 && rv_quiet, "R2 no response to a write", 64'(rsp_valid), 64'd0);
      begin
        logic [DW-1:0] v;
        v = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
        v = (v & ~lane_bits(m)) | (d & lane_bits(m));
        ref_mem[int'(a)] = v;
      end
    end else begin
      check(busy == RD_C, "R2 read busy length", 64'(busy), 64'(RD_C));
      check(pins_ok, "R3 read pin pattern", 64'({mem_oe_n, mem_we_n, mem_bw_n}), 64'({2'b01, ~m}));
      check(rv_quiet && rsp_valid === 1'b1, "R4 response pulse", 64'(rsp_valid), 64'd1);
      check(rsp_rdata === ref_read(a, m), "R4 read data lanes", 64'(rsp_rdata), 64'(ref_read(a, m)));
      check(data_ok, "R6 no drive during read", 64'(mem_dq_oe), 64'd0);
    end
    check(mem_ce_n === 1'b1 && mem_ce2 === 1'b0 && mem_bw_n === '1 && mem_dq_oe === 1'b0,
          "R1 pins idle after cycle", 64'({mem_ce_n, mem_ce2, mem_bw_n}), 64'({2'b10, {NL{1'b1}}}));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R4 response lasts one cycle", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED1234);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n === 1'b1 && mem_ce2 === 1'b0 && mem_oe_n === 1'b1 && mem_we_n === 1'b1 &&
          mem_bw_n === '1 && mem_dq_oe === 1'b0 && rsp_valid === 1'b0,
          "R1 pins in reset", 64'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}), 64'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && mem_ce_n === 1'b1, "R1 idle after reset",
          64'({req_ready, mem_ce_n}), 64'b11);

    // directed corners
    run_op(1'b0, 18'h00000, '0, 4'hF, 1'b0);              // unwritten word
    run_op(1'b1, 18'h3FFFF, 32'h11223344, 4'hF, 1'b0);    // top address, full
    run_op(1'b0, 18'h3FFFF, '0, 4'hF, 1'b0);
    run_op(1'b1, 18'h3FFFF, 32'hAABBCCDD, 4'h0, 1'b0);    // R8 empty mask
    run_op(1'b0, 18'h3FFFF, '0, 4'hF, 1'b0);
    run_op(1'b1, 18'h3FFFF, 32'hEEFF0099, 4'b0101, 1'b0); // R8 partial
    run_op(1'b0, 18'h3FFFF, '0, 4'b1010, 1'b0);           // R4 lane zeroing
    run_op(1'b0, 18'h3FFFF, '0, 4'h0, 1'b0);              // R4 all lanes off
    run_op(1'b1, 18'h00001, 32'h01020304, 4'hF, 1'b1);    // R9 intruding request
    run_op(1'b0, 18'h00001, '0, 4'hF, 1'b1);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      logic [31:0] rd;
      ra = $urandom;
      rd = $urandom;
      run_op(ra[20], pick_addr(ra), rd, ra[27:24], ra[30] & ra[29]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule